// File: doc/BRIEF.md
# Secure-Banked Bus Error Capture Unit

This unit is attached to one target-side access point of an on-chip interconnect. It watches every transaction that completes at that point. When a transaction ends with an error response, the unit records the failing address and a compact log word. The record goes into one of two register banks, chosen by the security attribute of the transaction: a Secure bank or a Non-Secure bank. Each bank drives its own level interrupt. That interrupt stays high until software clears the error through a 4 KB register window. Transactions started by non-processor initiators, such as DMA engines, are always recorded in the Non-Secure bank.

Each bank is a three-state machine:

- BK_IDLE: nothing has been captured.
- BK_HELD: a first error has been captured.
- BK_LOST: a first error is held and at least one later error was dropped.

The transitions are:

- capture: BK_IDLE to BK_HELD, on an error for the bank.
- lose: BK_HELD to BK_LOST, on a further error while one is held.
- clear: BK_HELD or BK_LOST to BK_IDLE, on a clearing write.
- clear-and-capture: any state to BK_HELD, when a clearing write and a new error for the same bank land in the same cycle.

The Non-Secure bank sits at window offset 0x000. The Secure bank is mirrored at offset 0x800. Secure register accesses may reach both banks; Non-Secure register accesses can only reach the Non-Secure bank.

Top module: `berr_capture_unit`

## Requirements
- R1: After reset both banks are in BK_IDLE, `irq_ns` and `irq_s` are low, and STATUS, LOG and ADDR of both banks read as zero.
- R2: A transaction with `txn_done`=1 and `txn_resp[1]`=1 is an error. When it targets a bank in BK_IDLE, that bank captures it, and from the next cycle the bank shows:
  - ADDR (offset 0x60) holds `txn_addr`.
  - LOG (offset 0x58) holds the ID in bits 15:0, `txn_resp` in bits 17:16 and `txn_write` in bit 18, with all other bits zero.
  - STATUS (offset 0x28) has bit 24 set.
- R3: Response codes with `txn_resp[1]`=0 (values 0 and 1) change no state.
- R4: An error with `txn_secure`=1 and `txn_from_dev`=0 goes to the Secure bank, whose registers sit at 0x828, 0x858 and 0x860. Any other error goes to the Non-Secure bank at 0x028, 0x058 and 0x060.
- R5: An error with `txn_from_dev`=1 goes to the Non-Secure bank whatever `txn_secure` says, and never changes the Secure bank.
- R6: While a bank holds an error, a further error for that bank sets STATUS bit 25 and leaves ADDR and LOG at the first error's values.
- R7: A write to a bank's STATUS with `reg_wdata[24]`=1 clears bits 24 and 25 of that bank from the next cycle. A write with bit 24 clear has no effect.
- R8: If a clearing write and a new error for the same bank fall in the same cycle, the new error is captured: bit 24 is set, bit 25 is clear, and ADDR and LOG hold the new error.
- R9: `irq_ns` and `irq_s` each equal STATUS bit 24 of their bank. An interrupt falls on the clock edge that performs the clearing write.
- R10: A Non-Secure register access (`reg_secure`=0) to offsets 0x800 and above reads zero and its writes are ignored. A Secure access reaches both windows.
- R11: `reg_rdata` is combinational: it shows the addressed register while `reg_en`=1 and `reg_we`=0, and is zero otherwise. Offsets other than 0x28, 0x58 and 0x60 within a window read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_done | input | 1 | A transaction completes this cycle |
| txn_resp | input | 2 | Response code; bit 1 set marks an error |
| txn_secure | input | 1 | Security attribute of the transaction (1 = Secure) |
| txn_from_dev | input | 1 | Transaction was started by a non-processor initiator |
| txn_write | input | 1 | 1 = write transaction, 0 = read |
| txn_id | input | ID_W | Transaction ID |
| txn_addr | input | ADDR_W | Transaction address |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Register access is a write |
| reg_secure | input | 1 | Register access is Secure |
| reg_addr | input | 12 | Byte offset within the 4 KB window |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| irq_ns | output | 1 | Non-Secure bus error interrupt (level) |
| irq_s | output | 1 | Secure bus error interrupt (level) |

## Verification
Results have two timings:

- Reads are combinational. The bench drives a read just after a falling edge and samples `reg_rdata` one nanosecond later, in the same cycle.
- Captures, clears and interrupt changes take effect on the rising edge that samples the stimulus. The bench drives at a falling edge and checks after the next edge.

For the clear case, the bench also confirms that the interrupt is still high before that edge. The simultaneous clear-and-error case drives both strobes in one cycle, so that the priority between them is decided by a single edge.

// File: rtl/berr_pkg.sv
package berr_pkg;

    typedef enum logic [1:0] {
        BK_IDLE = 2'd0,
        BK_HELD = 2'd1,
        BK_LOST = 2'd2
    } bank_state_e;

    localparam int unsigned NBANK    = 2;
    localparam int unsigned BANK_NS  = 0;
    localparam int unsigned BANK_S   = 1;

    localparam int unsigned REG_AW   = 12;
    localparam int unsigned REG_DW   = 64;

    localparam logic [10:0] OFF_STATUS = 11'h028;
    localparam logic [10:0] OFF_LOG    = 11'h058;
    localparam logic [10:0] OFF_ADDR   = 11'h060;

    localparam int unsigned ST_VALID = 24;
    localparam int unsigned ST_OVF   = 25;

    localparam int unsigned LG_RESP  = 16;
    localparam int unsigned LG_WR    = 18;

endpackage

// File: rtl/berr_bank.sv
module berr_bank
    import berr_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned ID_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_hit,
    input  logic              clr_hit,
    input  logic [ID_W-1:0]   rec_id,
    input  logic [1:0]        rec_resp,
    input  logic              rec_wr,
    input  logic [ADDR_W-1:0] rec_addr,
    output logic              held,
    output logic              lost,
    output logic [REG_DW-1:0] log_o,
    output logic [REG_DW-1:0] addr_o
);

    bank_state_e       state_q, state_d;
    logic              capture;
    logic [ID_W-1:0]   id_q;
    logic [1:0]        resp_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        if (clr_hit) begin
            state_d = err_hit ? BK_HELD : BK_IDLE;
            capture = err_hit;
        end else begin
            unique case (state_q)
                BK_IDLE: if (err_hit) begin
                    state_d = BK_HELD;
                    capture = 1'b1;
                end
                BK_HELD: if (err_hit) state_d = BK_LOST;
                BK_LOST: state_d = BK_LOST;
                default: state_d = BK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BK_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q   <= '0;
            resp_q <= '0;
            wr_q   <= 1'b0;
            addr_q <= '0;
        end else if (capture) begin
            id_q   <= rec_id;
            resp_q <= rec_resp;
            wr_q   <= rec_wr;
            addr_q <= rec_addr;
        end
    end

    always_comb begin
        held             = (state_q != BK_IDLE);
        lost             = (state_q == BK_LOST);
        log_o            = '0;
        log_o[ID_W-1:0]  = id_q;
        log_o[LG_RESP+:2] = resp_q;
        log_o[LG_WR]     = wr_q;
        addr_o           = REG_DW'(addr_q);
    end

    // R2: a fresh error in an idle bank is captured on the next edge
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (err_hit && !held) |=> (held && addr_q == $past(rec_addr)));

    // R6: the first record stays put while the bank is occupied
    a_r6_keep_first: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !clr_hit) |=> ($stable(addr_q) && $stable(id_q) && $stable(resp_q)));

    // R6: a second error marks overflow
    a_r6_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (held && err_hit && !clr_hit) |=> lost);

    // R9: interrupt level drops after a clear with no new error
    a_r9_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !err_hit) |=> (!held && !lost));

    // R8: clear and error together leave a fresh capture
    a_r8_clear_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && err_hit) |=> (held && !lost && addr_q == $past(rec_addr)));

endmodule

// File: rtl/berr_regmux.sv
module berr_regmux
    import berr_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_en,
    input  logic                         reg_we,
    input  logic                         reg_secure,
    input  logic [REG_AW-1:0]            reg_addr,
    input  logic [REG_DW-1:0]            reg_wdata,
    input  logic [NBANK-1:0]             held,
    input  logic [NBANK-1:0]             lost,
    input  logic [NBANK-1:0][REG_DW-1:0] log_w,
    input  logic [NBANK-1:0][REG_DW-1:0] addr_w,
    output logic [NBANK-1:0]             clr,
    output logic [REG_DW-1:0]            rdata
);

    logic        win;
    logic        allowed;
    logic [10:0] off;
    logic        unused_wdata;

    assign win          = reg_addr[REG_AW-1];
    assign off          = reg_addr[REG_AW-2:0];
    assign allowed      = !win || reg_secure;
    assign unused_wdata = ^{reg_wdata[REG_DW-1:ST_VALID+1], reg_wdata[ST_VALID-1:0]};

    always_comb begin
        rdata = '0;
        clr   = '0;
        if (reg_en && allowed) begin
            if (!reg_we) begin
                case (off)
                    OFF_STATUS: begin
                        rdata[ST_VALID] = held[win];
                        rdata[ST_OVF]   = lost[win];
                    end
                    OFF_LOG:  rdata = log_w[win];
                    OFF_ADDR: rdata = addr_w[win];
                    default:  rdata = '0;
                endcase
            end else if (off == OFF_STATUS && reg_wdata[ST_VALID]) begin
                clr[win] = 1'b1;
            end
        end
    end

    // R10: Non-Secure accesses to the Secure window see nothing and clear nothing
    a_r10_ns_window: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_secure && win) |-> (rdata == '0 && clr == '0));

    // R11: no read data without a read strobe
    a_r11_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_en || reg_we) |-> (rdata == '0));

endmodule

// File: rtl/berr_capture_unit.sv
module berr_capture_unit
    import berr_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned ID_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_done,
    input  logic [1:0]        txn_resp,
    input  logic              txn_secure,
    input  logic              txn_from_dev,
    input  logic              txn_write,
    input  logic [ID_W-1:0]   txn_id,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic              reg_secure,
    input  logic [11:0]       reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              irq_ns,
    output logic              irq_s
);

    logic                         is_err;
    logic                         to_secure;
    logic [NBANK-1:0]             err_hit;
    logic [NBANK-1:0]             clr;
    logic [NBANK-1:0]             held;
    logic [NBANK-1:0]             lost;
    logic [NBANK-1:0][REG_DW-1:0] log_w;
    logic [NBANK-1:0][REG_DW-1:0] addr_w;

    assign is_err    = txn_done && txn_resp[1];
    assign to_secure = txn_secure && !txn_from_dev;

    always_comb begin
        err_hit          = '0;
        err_hit[BANK_NS] = is_err && !to_secure;
        err_hit[BANK_S]  = is_err && to_secure;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        berr_bank #(
            .ADDR_W (ADDR_W),
            .ID_W   (ID_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .err_hit  (err_hit[b]),
            .clr_hit  (clr[b]),
            .rec_id   (txn_id),
            .rec_resp (txn_resp),
            .rec_wr   (txn_write),
            .rec_addr (txn_addr),
            .held     (held[b]),
            .lost     (lost[b]),
            .log_o    (log_w[b]),
            .addr_o   (addr_w[b])
        );
    end

    berr_regmux u_regmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_en     (reg_en),
        .reg_we     (reg_we),
        .reg_secure (reg_secure),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .held       (held),
        .lost       (lost),
        .log_w      (log_w),
        .addr_w     (addr_w),
        .clr        (clr),
        .rdata      (reg_rdata)
    );

    assign irq_ns = held[BANK_NS];
    assign irq_s  = held[BANK_S];

    // R5: device-initiated errors never raise the Secure interrupt
    a_r5_device_ns: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_done && txn_from_dev && !irq_s) |=> !irq_s);

    // R3: OK responses leave both interrupts unchanged
    a_r3_ok_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_done && !txn_resp[1] && !reg_en) |=> ($stable(irq_ns) && $stable(irq_s)));

    // R4: a Secure processor error never touches the Non-Secure interrupt
    a_r4_secure_route: assert property (@(posedge clk) disable iff (!rst_n)
        (is_err && to_secure && !irq_ns && !reg_en) |=> (irq_s && !irq_ns));

endmodule

// File: tb/sim_berr_capture_unit.sv
`timescale 1ns/1ps
module sim_berr_capture_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_done = 1'b0;
    logic [1:0]  txn_resp = '0;
    logic        txn_secure = 1'b0;
    logic        txn_from_dev = 1'b0;
    logic        txn_write = 1'b0;
    logic [15:0] txn_id = '0;
    logic [63:0] txn_addr = '0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_secure = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq_ns;
    logic        irq_s;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    berr_capture_unit u0 (
        .clk(clk), .rst_n(rst_n), .txn_done(txn_done), .txn_resp(txn_resp),
        .txn_secure(txn_secure), .txn_from_dev(txn_from_dev), .txn_write(txn_write),
        .txn_id(txn_id), .txn_addr(txn_addr), .reg_en(reg_en), .reg_we(reg_we),
        .reg_secure(reg_secure), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_ns(irq_ns), .irq_s(irq_s)
    );

    // vector: {sec, dev, resp[1:0], wr, id[15:0], addr[31:0]}
    localparam logic [52:0] VEC [8] = '{
        {1'b0, 1'b0, 2'd2, 1'b0, 16'h0001, 32'h1000_0000},
        {1'b1, 1'b0, 2'd3, 1'b1, 16'hBEEF, 32'h2000_0040},
        {1'b1, 1'b1, 2'd2, 1'b1, 16'h0042, 32'h3000_0008},
        {1'b0, 1'b1, 2'd3, 1'b0, 16'hFFFF, 32'h4000_0010},
        {1'b1, 1'b0, 2'd0, 1'b1, 16'h0007, 32'h5000_0000},
        {1'b0, 1'b0, 2'd1, 1'b0, 16'h0009, 32'h6000_0000},
        {1'b1, 1'b0, 2'd2, 1'b0, 16'h8000, 32'hFFFF_FFF8},
        {1'b0, 1'b0, 2'd2, 1'b1, 16'h1234, 32'h0000_0000}
    };

    task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic txn(input logic sec, input logic dev, input logic [1:0] resp,
                       input logic wr, input logic [15:0] id, input logic [63:0] addr);
        @(negedge clk);
        txn_done = 1'b1; txn_secure = sec; txn_from_dev = dev;
        txn_resp = resp; txn_write = wr; txn_id = id; txn_addr = addr;
        @(negedge clk);
        txn_done = 1'b0;
    endtask

    task automatic rd(input logic sec, input logic [11:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_secure = sec; reg_addr = a;
        #1 d = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic wr_reg(input logic sec, input logic [11:0] a, input logic [63:0] v);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_secure = sec; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    function automatic logic [63:0] logw(input logic wr, input logic [1:0] resp,
                                         input logic [15:0] id);
        return {45'b0, wr, resp, id};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq_ns after reset", {63'b0, irq_ns}, 64'd0);
        chk("R1 irq_s after reset", {63'b0, irq_s}, 64'd0);
        rd(1'b0, 12'h028, d); chk("R1 NS STATUS", d, 64'd0);
        rd(1'b1, 12'h828, d); chk("R1 S STATUS", d, 64'd0);
        rd(1'b1, 12'h858, d); chk("R1 S LOG", d, 64'd0);
        rd(1'b0, 12'h060, d); chk("R1 NS ADDR", d, 64'd0);

        // Table walk: R2 R3 R4 R5
        for (int i = 0; i < 8; i++) begin
            logic        v_sec, v_dev, v_wr, v_err, v_tos;
            logic [1:0]  v_resp;
            logic [15:0] v_id;
            logic [63:0] v_addr;
            logic [11:0] base;
            {v_sec, v_dev, v_resp, v_wr, v_id, v_addr[31:0]} = VEC[i];
            v_addr[63:32] = ~v_addr[31:0];
            v_err = v_resp[1];
            v_tos = v_sec && !v_dev;
            wr_reg(1'b1, 12'h028, 64'h0100_0000);
            wr_reg(1'b1, 12'h828, 64'h0100_0000);
            txn(v_sec, v_dev, v_resp, v_wr, v_id, v_addr);
            chk($sformatf("R4 R5 vec%0d irq_s", i), {63'b0, irq_s}, {63'b0, v_err && v_tos});
            chk($sformatf("R4 R5 vec%0d irq_ns", i), {63'b0, irq_ns}, {63'b0, v_err && !v_tos});
            if (v_err) begin
                base = v_tos ? 12'h800 : 12'h000;
                rd(1'b1, base | 12'h028, d); chk($sformatf("R2 vec%0d STATUS", i), d, 64'h0100_0000);
                rd(1'b1, base | 12'h058, d); chk($sformatf("R2 vec%0d LOG", i), d, logw(v_wr, v_resp, v_id));
                rd(1'b1, base | 12'h060, d); chk($sformatf("R2 vec%0d ADDR", i), d, v_addr);
                rd(1'b1, base ^ 12'h828, d); chk($sformatf("R4 vec%0d other STATUS", i), d, 64'd0);
            end else begin
                rd(1'b1, 12'h028, d); chk($sformatf("R3 vec%0d NS STATUS", i), d, 64'd0);
                rd(1'b1, 12'h828, d); chk($sformatf("R3 vec%0d S STATUS", i), d, 64'd0);
            end
        end
        wr_reg(1'b1, 12'h028, 64'h0100_0000);
        wr_reg(1'b1, 12'h828, 64'h0100_0000);

        // R6: first error kept, overflow flagged
        txn(1'b0, 1'b0, 2'd2, 1'b0, 16'h00AA, 64'hAAAA_0000_0000_1000);
        txn(1'b0, 1'b0, 2'd3, 1'b1, 16'h00BB, 64'hBBBB_0000_0000_2000);
        rd(1'b0, 12'h028, d); chk("R6 overflow STATUS", d, 64'h0300_0000);
        rd(1'b0, 12'h060, d); chk("R6 first ADDR kept", d, 64'hAAAA_0000_0000_1000);
        rd(1'b0, 12'h058, d); chk("R6 first LOG kept", d, logw(1'b0, 2'd2, 16'h00AA));

        // R11: no strobe and unused offset read zero
        @(negedge clk);
        reg_en = 1'b0; reg_addr = 12'h028;
        #1 chk("R11 rdata without strobe", reg_rdata, 64'd0);
        rd(1'b0, 12'h030, d); chk("R11 unused offset", d, 64'd0);

        // R7: write without bit 24 has no effect
        wr_reg(1'b0, 12'h028, 64'h0200_0000);
        rd(1'b0, 12'h028, d); chk("R7 non-clearing write", d, 64'h0300_0000);

        // R9: interrupt stays up until the clearing edge, then drops
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_secure = 1'b0; reg_addr = 12'h028; reg_wdata = 64'h0100_0000;
        #1 chk("R9 irq_ns before clearing edge", {63'b0, irq_ns}, 64'd1);
        @(posedge clk); #1;
        chk("R9 irq_ns after clearing edge", {63'b0, irq_ns}, 64'd0);
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
        rd(1'b0, 12'h028, d); chk("R7 cleared STATUS", d, 64'd0);

        // R8: clear and new error in the same cycle
        txn(1'b0, 1'b0, 2'd2, 1'b0, 16'h0011, 64'h1111);
        txn(1'b0, 1'b0, 2'd2, 1'b0, 16'h0022, 64'h2222);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_secure = 1'b0; reg_addr = 12'h028; reg_wdata = 64'h0100_0000;
        txn_done = 1'b1; txn_secure = 1'b0; txn_from_dev = 1'b0; txn_resp = 2'd3;
        txn_write = 1'b1; txn_id = 16'h0033; txn_addr = 64'h3333;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; txn_done = 1'b0;
        rd(1'b0, 12'h028, d); chk("R8 STATUS after clear+error", d, 64'h0100_0000);
        rd(1'b0, 12'h060, d); chk("R8 ADDR is new error", d, 64'h3333);
        rd(1'b0, 12'h058, d); chk("R8 LOG is new error", d, logw(1'b1, 2'd3, 16'h0033));
        wr_reg(1'b0, 12'h028, 64'h0100_0000);

        // R10: Non-Secure access cannot see or clear the Secure bank
        txn(1'b1, 1'b0, 2'd2, 1'b1, 16'h0D0D, 64'hDDDD_0000);
        rd(1'b0, 12'h828, d); chk("R10 NS read of S STATUS", d, 64'd0);
        rd(1'b0, 12'h860, d); chk("R10 NS read of S ADDR", d, 64'd0);
        wr_reg(1'b0, 12'h828, 64'h0100_0000);
        chk("R10 NS clear ignored, irq_s", {63'b0, irq_s}, 64'd1);
        rd(1'b1, 12'h860, d); chk("R10 S read of S ADDR", d, 64'hDDDD_0000);
        txn(1'b0, 1'b0, 2'd2, 1'b0, 16'h0E0E, 64'hEEEE);
        rd(1'b1, 12'h060, d); chk("R10 S read of NS ADDR", d, 64'hEEEE);
        wr_reg(1'b1, 12'h828, 64'h0100_0000);
        chk("R9 irq_s after Secure clear", {63'b0, irq_s}, 64'd0);
        chk("R9 irq_ns unaffected by Secure clear", {63'b0, irq_ns}, 64'd1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule